// File: doc/BRIEF.md
# Clock Page Replacement Engine

This block picks which physical page to evict when a new page must be brought into memory. It keeps one "recently used" flag per physical page and a rotating pointer (the hand) that sweeps around the pages as a ring. Whenever a page is touched, its flag is raised through the reference port. When a replacement is needed, a single request pulse starts a sweep at the current hand position. The sweep looks at one page per clock cycle.

A page whose flag is up gets a second chance: its flag is dropped and the hand moves on. The first page found with its flag down becomes the victim. The block reports that victim together with a one-cycle completion strobe. It then raises the victim's flag, because the victim now holds the freshly loaded page, and parks the hand just past it.

Writing pages back, moving data and updating page tables are handled elsewhere.

Top module: `clock_repl_engine`

## Requirements
- R1: After reset, every use flag is clear, the hand is at page 0, and `busy` and `done` are low. A first request therefore returns victim 0 after a single check.
- R2: A cycle with `ref_valid` high raises the use flag of page `ref_page` at the next clock edge, so a later sweep passes over that page instead of choosing it.
- R3: A request accepted while idle starts a sweep at the hand position. The sweep checks one page per cycle. A page with its flag set has that flag cleared and the hand advances. If the sweep skips j pages, `done` is high in cycle j+1 after the cycle in which the request was taken.
- R4: The first page found with its flag clear is the victim. Its index is on `victim` during the single cycle in which `done` is high, and `done` is high for exactly one cycle per sweep.
- R5: The victim's use flag is set when the victim is chosen. If no reference arrives in between, the next sweep therefore skips it.
- R6: After a sweep, the hand points at the page after the victim. Page N-1 is followed by page 0.
- R7: If no reference arrives during a sweep, the sweep ends within N+1 checks. This is the case when every flag is set: one full lap clears them all, and the sweep returns to the starting page.
- R8: If a reference and a sweep clear target the same page in the same cycle, the reference wins and that page's flag stays set.
- R9: A request that arrives while `busy` is high is ignored. It neither starts a second sweep nor produces a second `done`.
- R10: `busy` is high from the cycle after a request is accepted up to and including the cycle of the last check. It is low in the cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ref_valid | input | 1 | Marks page `ref_page` as recently used |
| ref_page | input | $clog2(NUM_PAGES) | Index of the referenced page |
| req | input | 1 | Request a victim; taken only while idle |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle strobe: `victim` is valid |
| victim | output | $clog2(NUM_PAGES) | Index of the chosen page |

## Verification
A request sampled at one rising edge moves the engine into its sweep. The first check happens at the following edge, and each further skipped page adds one edge. The bench therefore predicts the exact number of cycles until `done`, which is the count of pages its own model skips plus one. It counts falling edges from the request and compares both that count and the victim index when `done` first appears. All inputs change and all outputs are sampled on falling edges. Flag and hand effects that cannot be seen directly are checked through the victim and latency of the following sweep. The one-cycle strobe, the absent second strobe after a duplicate request, and `busy` are each sampled in the single cycle where the requirement fixes them.

// File: rtl/clock_repl_pkg.sv
package clock_repl_pkg;

    typedef enum logic {
        SW_IDLE = 1'b0,
        SW_SCAN = 1'b1
    } sweep_state_e;

    // Ring successor of a page index for a ring of n pages.
    function automatic int unsigned ring_next(input int unsigned idx, input int unsigned n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/clock_use_flags.sv
module clock_use_flags #(
    parameter int NUM_PAGES = 8,
    parameter int IDX_W     = $clog2(NUM_PAGES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ref_valid,
    input  logic [IDX_W-1:0]     ref_page,
    input  logic                 clr_en,
    input  logic [IDX_W-1:0]     clr_idx,
    input  logic                 set_en,
    input  logic [IDX_W-1:0]     set_idx,
    output logic [NUM_PAGES-1:0] use_bits
);
    for (genvar g = 0; g < NUM_PAGES; g++) begin : g_flag
        logic flag_q;
        logic hit_ref;
        logic hit_set;
        logic hit_clr;

        always_comb begin
            hit_ref = ref_valid && (ref_page == IDX_W'(g));
            hit_set = set_en && (set_idx == IDX_W'(g));
            hit_clr = clr_en && (clr_idx == IDX_W'(g));
        end

        // A raise (reference or victim load) outranks a sweep clear.
        always_ff @(posedge clk) begin
            if (rst) begin
                flag_q <= 1'b0;
            end else if (hit_ref || hit_set) begin
                flag_q <= 1'b1;
            end else if (hit_clr) begin
                flag_q <= 1'b0;
            end
        end

        assign use_bits[g] = flag_q;
    end
endmodule

// File: rtl/clock_hand_fsm.sv
module clock_hand_fsm
    import clock_repl_pkg::*;
#(
    parameter int NUM_PAGES = 8,
    parameter int IDX_W     = $clog2(NUM_PAGES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req,
    input  logic [NUM_PAGES-1:0] use_bits,
    output logic                 clr_en,
    output logic [IDX_W-1:0]     clr_idx,
    output logic                 set_en,
    output logic [IDX_W-1:0]     set_idx,
    output logic [IDX_W-1:0]     hand,
    output logic                 busy,
    output logic                 done,
    output logic [IDX_W-1:0]     victim
);
    sweep_state_e     state_q;
    logic [IDX_W-1:0] hand_q;
    logic [IDX_W-1:0] hand_nxt;
    logic             done_q;
    logic [IDX_W-1:0] victim_q;
    logic             scanning;
    logic             cur_used;

    always_comb begin
        scanning = (state_q == SW_SCAN);
        cur_used = use_bits[hand_q];
        hand_nxt = IDX_W'(ring_next(32'(hand_q), NUM_PAGES));
        clr_en   = scanning && cur_used;
        set_en   = scanning && !cur_used;
        clr_idx  = hand_q;
        set_idx  = hand_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SW_IDLE;
            hand_q   <= '0;
            done_q   <= 1'b0;
            victim_q <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                SW_IDLE: begin
                    if (req) begin
                        state_q <= SW_SCAN;
                    end
                end
                SW_SCAN: begin
                    hand_q <= hand_nxt;
                    if (!cur_used) begin
                        victim_q <= hand_q;
                        done_q   <= 1'b1;
                        state_q  <= SW_IDLE;
                    end
                end
                default: state_q <= SW_IDLE;
            endcase
        end
    end

    assign hand   = hand_q;
    assign busy   = scanning;
    assign done   = done_q;
    assign victim = victim_q;
endmodule

// File: rtl/clock_repl_engine.sv
module clock_repl_engine #(
    parameter int NUM_PAGES = 8,
    localparam int IDX_W    = $clog2(NUM_PAGES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_valid,
    input  logic [IDX_W-1:0] ref_page,
    input  logic             req,
    output logic             busy,
    output logic             done,
    output logic [IDX_W-1:0] victim
);
    logic [NUM_PAGES-1:0] use_bits;
    logic                 clr_en;
    logic [IDX_W-1:0]     clr_idx;
    logic                 set_en;
    logic [IDX_W-1:0]     set_idx;
    logic [IDX_W-1:0]     hand;

    clock_use_flags #(.NUM_PAGES(NUM_PAGES), .IDX_W(IDX_W)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .ref_valid(ref_valid),
        .ref_page (ref_page),
        .clr_en   (clr_en),
        .clr_idx  (clr_idx),
        .set_en   (set_en),
        .set_idx  (set_idx),
        .use_bits (use_bits)
    );

    clock_hand_fsm #(.NUM_PAGES(NUM_PAGES), .IDX_W(IDX_W)) u_hand (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .use_bits(use_bits),
        .clr_en  (clr_en),
        .clr_idx (clr_idx),
        .set_en  (set_en),
        .set_idx (set_idx),
        .hand    (hand),
        .busy    (busy),
        .done    (done),
        .victim  (victim)
    );
endmodule

// File: rtl/clock_repl_checker.sv
module clock_repl_checker #(
    parameter int NUM_PAGES = 8,
    parameter int IDX_W     = $clog2(NUM_PAGES)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 ref_valid,
    input logic [IDX_W-1:0]     ref_page,
    input logic                 req,
    input logic                 busy,
    input logic                 done,
    input logic [IDX_W-1:0]     victim,
    input logic [NUM_PAGES-1:0] use_bits,
    input logic [IDX_W-1:0]     hand
);
    logic [IDX_W+1:0] busy_cnt;
    logic             ref_seen;

    always_ff @(posedge clk) begin
        if (rst || !busy) begin
            busy_cnt <= '0;
            ref_seen <= 1'b0;
        end else begin
            busy_cnt <= busy_cnt + 1'b1;
            ref_seen <= ref_seen | ref_valid;
        end
    end

    a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r10_req_starts: assert property (@(posedge clk) disable iff (rst)
        (req && !busy) |=> busy);

    a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r8_ref_wins: assert property (@(posedge clk) disable iff (rst)
        ref_valid |=> use_bits[$past(ref_page)]);

    a_r5_victim_flag: assert property (@(posedge clk) disable iff (rst)
        done |-> use_bits[victim]);

    a_r6_hand_past_victim: assert property (@(posedge clk) disable iff (rst)
        done |-> (hand == ((victim == IDX_W'(NUM_PAGES - 1)) ? '0 : victim + 1'b1)));

    a_r7_sweep_bound: assert property (@(posedge clk) disable iff (rst)
        (busy && !ref_seen) |-> (busy_cnt < (IDX_W+2)'(NUM_PAGES + 1)));
endmodule

bind clock_repl_engine clock_repl_checker #(.NUM_PAGES(NUM_PAGES), .IDX_W(IDX_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ref_valid(ref_valid),
    .ref_page (ref_page),
    .req      (req),
    .busy     (busy),
    .done     (done),
    .victim   (victim),
    .use_bits (use_bits),
    .hand     (hand)
);

// File: tb/sim_clock_repl_engine.sv
module sim_clock_repl_engine;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 8;
    localparam int IW         = $clog2(N);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ref_valid = 1'b0;
    logic [IW-1:0] ref_page = '0;
    logic          req = 1'b0;
    logic          busy;
    logic          done;
    logic [IW-1:0] victim;

    int checks = 0;
    int errors = 0;

    // Bench model of the spec: flags and hand.
    bit m_use [N];
    int m_hand = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clock_repl_engine #(.NUM_PAGES(N)) u0 (
        .clk(clk), .rst(rst), .ref_valid(ref_valid), .ref_page(ref_page),
        .req(req), .busy(busy), .done(done), .victim(victim)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int nxt(input int i);
        return (i + 1 >= N) ? 0 : i + 1;
    endfunction

    // Spec sweep with no references during it: returns victim and check count.
    task automatic model_sweep(output int v, output int nchk);
        nchk = 0;
        v = -1;
        while (v < 0) begin
            nchk++;
            if (m_use[m_hand]) m_use[m_hand] = 0;
            else begin
                v = m_hand;
                m_use[m_hand] = 1;
            end
            m_hand = nxt(m_hand);
        end
    endtask

    task automatic do_ref(input int p);
        ref_valid = 1'b1;
        ref_page  = IW'(p);
        m_use[p]  = 1;
        @(negedge clk);
        ref_valid = 1'b0;
    endtask

    // Issue a request; compare latency and victim with expectations.
    task automatic run_req(input int exp_v, input int exp_cyc, input bit dup, input string tag);
        int cyc;
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        chk(busy === 1'b1, "R10 busy after accept", int'(busy), 1);
        cyc = 0;
        while (done !== 1'b1 && cyc < 4*N + 10) begin
            if (dup && cyc == 0) req = 1'b1;
            @(negedge clk);
            req = 1'b0;
            cyc++;
        end
        chk(cyc == exp_cyc, {tag, " latency"}, cyc, exp_cyc);
        chk(int'(victim) == exp_v, {tag, " victim"}, int'(victim), exp_v);
        chk(busy === 1'b0, "R10 busy low with done", int'(busy), 0);
        @(negedge clk);
        chk(done === 1'b0, "R4 done single cycle", int'(done), 0);
    endtask

    task automatic model_req(input bit dup, input string tag);
        int v, n;
        model_sweep(v, n);
        run_req(v, n, dup, tag);
    endtask

    initial begin
        int h, okq;
        for (int i = 0; i < N; i++) m_use[i] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(busy === 1'b0 && done === 1'b0, "R1 reset outputs", int'({busy, done}), 0);

        // R1/R6: sequential victims from reset, wrapping around the ring.
        for (int i = 0; i < N; i++) model_req(1'b0, "R1 R6 fresh victim");
        // R7: every flag set, a full lap then victim at start page (N+1 checks).
        run_req(0, N + 1, 1'b0, "R7 full lap");
        m_hand = 1;
        for (int i = 0; i < N; i++) m_use[i] = (i == 0);

        // R5: victim 0 flag set, so next sweep from hand 1 takes page 1 at once.
        model_req(1'b0, "R5 fresh victim flag");

        // R2: raise flags on pages ahead of the hand and see them skipped.
        do_ref(m_hand);
        do_ref(nxt(m_hand));
        model_req(1'b0, "R2 referenced pages skipped");

        // R9: duplicate request during a long sweep is ignored.
        for (int i = 0; i < N; i++) do_ref(i);
        model_req(1'b1, "R9 dup request");
        okq = 1;
        for (int i = 0; i < N + 3; i++) begin
            if (done !== 1'b0 || busy !== 1'b0) okq = 0;
            @(negedge clk);
        end
        chk(okq == 1, "R9 no second sweep", okq, 1);

        // R8: reference hits the page being cleared in the first check cycle.
        for (int i = 0; i < N; i++) do_ref(i);
        h = m_hand;
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        ref_valid = 1'b1;
        ref_page = IW'(h);
        begin
            int cyc = 0;
            while (done !== 1'b1 && cyc < 4*N + 10) begin
                @(negedge clk);
                ref_valid = 1'b0;
                cyc++;
            end
            chk(cyc == N + 2, "R8 ref wins latency", cyc, N + 2);
            chk(int'(victim) == nxt(h), "R8 ref wins victim", int'(victim), nxt(h));
        end
        @(negedge clk);
        for (int i = 0; i < N; i++) m_use[i] = (i == nxt(h));
        m_hand = nxt(nxt(h));

        // R3: constrained random references between requests.
        void'($urandom(32'h5eed1234));
        for (int it = 0; it < 60; it++) begin
            int nr = $urandom_range(0, 5);
            for (int k = 0; k < nr; k++) do_ref($urandom_range(0, N - 1));
            model_req(1'b0, "R3 random sweep");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule